// File: doc/BRIEF.md
# Two-Register Control Target on a Two-Wire Serial Bus

This block is a serial-bus target that owns a small control register file (two 8-bit registers by default). It works entirely in the system clock domain: the bus clock and data lines arrive as oversampled levels and pass through a short synchronizer. From the synchronized levels the block recovers the bus edges and decodes the frame. The only thing it drives back is an open-drain pull-down enable for the data line.

A host reaches the registers in three ways:
- **Write.** The host sends the device address with the write flag, then a register index byte, then any number of data bytes. The index advances after each data byte and wraps from the last register back to register 0.
- **Current-position read.** The host sends the device address with the read flag and receives data starting one past the register it touched last.
- **Random read.** The host writes only the index, issues a repeated START, and reads from that index.

The 7-bit device address is a fixed 5-bit prefix (binary 00100) followed by two strap inputs. On a foreign address the target stays silent until the bus is framed again by a START or STOP. An active-low reset clears every register to 00H.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: The first byte after START is matched against {00100, strap_i[1], strap_i[0]} in bits 7..1; bit 0 set means read and clear means write. On a match the target pulls SDA low for the ninth clock.
- R2: On an address mismatch no acknowledge is given. Every following byte, written or read, leaves SDA released and the registers unchanged until the next START or STOP.
- R3: In a write, the second byte sets the register index from its bit 0; its upper bits are ignored. The byte is acknowledged.
- R4: Each further write byte is shifted in MSB first and stored to the indexed register, where register i sits at regs_o[8*i+7:8*i]. The byte is acknowledged, and the index then advances, wrapping from 01H to 00H.
- R5: A read that directly follows an address byte with the read flag returns the register one past the last one accessed.
- R6: A random read (index write, repeated START, address with the read flag) returns the indexed register first. While the host acknowledges, further bytes follow with the index advancing and wrapping.
- R7: A host not-acknowledge ends a read. SDA stays released, and the index is left one past the last byte sent, so the next current-position read starts there.
- R8: SDA falling while SCL is high is a START; SDA rising while SCL is high is a STOP. A START in the middle of a byte abandons that byte without a write and re-arms the address phase. After a STOP the target releases SDA.
- R9: Reset clears every register to 00H, returns the index to 00H and releases SDA.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset (power-down) |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | STRAP_W (2) | Low address bits from strap pins |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NUM_REGS*8 (16) | Register contents, register i at bits 8*i+7..8*i |

## Verification
Two actions can land on the same recovered SCL falling edge:
- committing a write byte into a register, and
- wrapping the register index from the last register back to 00H.

A two-byte burst starting at index 01H provokes this coincidence. A current-position read then follows. It must return register 01H first and register 00H second, and the stored contents of both registers must match what was written. A second coincidence is a START arriving mid-byte. It must discard the partial shift without producing a register strobe; this is judged by reading the untouched register back after the repeated START.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } i2cr_state_e;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[SYNC_STAGES-1];
  assign sda_s      = sda_pipe[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // Data edges while the clock stays high frame the transfer.
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile #(
  parameter int unsigned NUM_REGS = 2,
  parameter int unsigned PTR_W    = 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [PTR_W-1:0]                    waddr_i,
  input  logic [i2cr_pkg::BYTE_W-1:0]          wdata_i,
  input  logic [PTR_W-1:0]                    raddr_i,
  output logic [i2cr_pkg::BYTE_W-1:0]          rdata_o,
  output logic [NUM_REGS*i2cr_pkg::BYTE_W-1:0] regs_o
);
  localparam int unsigned BW = i2cr_pkg::BYTE_W;
  logic [BW-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem[i] <= '0;
      else if (we_i && waddr_i == PTR_W'(i))     mem[i] <= wdata_i;
    end
    assign regs_o[i*BW +: BW] = mem[i];
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2cr_fsm.sv
module i2cr_fsm
  import i2cr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 2,
  parameter int unsigned PTR_W    = 1,
  parameter int unsigned STRAP_W  = 2,
  parameter int unsigned PREFIX   = 'b00100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rdata_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               we_o,
  output logic [BYTE_W-1:0]  wdata_o,
  output logic               sda_oe_o,
  output logic               ignore_o
);
  localparam int unsigned PREFIX_W = ADDR_W - STRAP_W;

  i2cr_state_e       state_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] shift_q;
  logic [PTR_W-1:0]  ptr_q, ptr_nxt;
  logic              oe_q, rw_q, mack_q;
  logic [ADDR_W-1:0] dev_addr;

  assign dev_addr = {PREFIX_W'(PREFIX), strap_i};
  assign ptr_nxt  = (ptr_q == PTR_W'(NUM_REGS-1)) ? '0 : ptr_q + 1'b1;
  assign we_o     = scl_fall_i && state_q == ST_WR && bit_q == 4'd8;
  assign wdata_o  = shift_q;
  assign ptr_o    = ptr_q;
  assign sda_oe_o = oe_q;
  assign ignore_o = state_q == ST_SKIP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise_i) begin
            shift_q <= {shift_q[BYTE_W-2:0], sda_i};
            bit_q   <= bit_q + 1'b1;
          end else if (scl_fall_i && bit_q == 4'd8) begin
            bit_q <= '0;
            if (state_q == ST_ADDR) begin
              if (shift_q[BYTE_W-1:1] == dev_addr) begin
                oe_q    <= 1'b1;
                rw_q    <= shift_q[0];
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (state_q == ST_SUB) begin
              ptr_q   <= shift_q[PTR_W-1:0];
              oe_q    <= 1'b1;
              state_q <= ST_SUB_ACK;
            end else begin
              ptr_q   <= ptr_nxt;
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_SUB_ACK, ST_WR_ACK: begin
          if (scl_fall_i) begin
            oe_q <= 1'b0;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              state_q <= ST_RD;
              shift_q <= rdata_i;
              oe_q    <= ~rdata_i[BYTE_W-1];
              bit_q   <= '0;
            end else if (state_q == ST_ADDR_ACK) begin
              state_q <= ST_SUB;
            end else begin
              state_q <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (bit_q == 4'd7) begin
              oe_q    <= 1'b0;
              ptr_q   <= ptr_nxt;
              bit_q   <= '0;
              state_q <= ST_RD_ACK;
            end else begin
              bit_q   <= bit_q + 1'b1;
              shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
              oe_q    <= ~shift_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_q <= ST_RD;
              shift_q <= rdata_i;
              oe_q    <= ~rdata_i[BYTE_W-1];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs #(
  parameter int unsigned NUM_REGS    = 2,
  parameter int unsigned STRAP_W     = 2,
  parameter int unsigned PREFIX      = 'b00100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic sda_w, rise_w, fall_w, start_w, stop_w, we_w, ignore_w;
  logic [PTR_W-1:0] ptr_w;
  logic [7:0] wdata_w, rdata_w;

  i2cr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2cr_fsm #(
    .NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .STRAP_W(STRAP_W), .PREFIX(PREFIX)
  ) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_w), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
    .start_i(start_w), .stop_i(stop_w), .strap_i, .rdata_i(rdata_w),
    .ptr_o(ptr_w), .we_o(we_w), .wdata_o(wdata_w), .sda_oe_o, .ignore_o(ignore_w)
  );

  i2cr_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni, .we_i(we_w), .waddr_i(ptr_w), .wdata_i(wdata_w),
    .raddr_i(ptr_w), .rdata_o(rdata_w), .regs_o
  );
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker #(
  parameter int unsigned REGS_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_i,
  input logic              stop_i,
  input logic              ignore_i,
  input logic [REGS_W-1:0] regs_i
);
  assert_reset_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!sda_oe_i && regs_i == '0));

  assert_drive_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_i);

  assert_write_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_i) |-> !scl_i);

  assert_release_on_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_silent_when_ignoring_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_i |-> !sda_oe_i);
endmodule

bind i2c_ctrl_regs i2cr_checker #(.REGS_W(NUM_REGS*8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_i(sda_oe_o),
  .stop_i(stop_w), .ignore_i(ignore_w), .regs_i(regs_o)
);

// File: tb/tb_i2c_ctrl_regs.sv
`timescale 1ns/1ps
module tb_i2c_ctrl_regs;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h24, AR = 8'h25, FW = 8'h22, FR = 8'h23;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [15:0] regs;
  wire sda_w = sda_m & ~sda_oe;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  i2c_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_w),
    .strap_i(2'b10), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic tx_bit(input logic b);
    wq(); sda_m = b; wq(); scl = 1'b1; wq(2); scl = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) tx_bit(b[i]);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_w; wq(); scl = 1'b0; wq();
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_w; wq(); scl = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl = 1'b1; wq(2); scl = 1'b0; sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check("R9 reset regs", regs, 16'h0000);
    check("R9 reset sda", sda_oe, 1'b0);
  endtask

  task automatic t_single_write();
    logic a;
    bus_start();
    tx_byte(AW, a); check("R1 addr ack", a, 1'b1);
    tx_byte(8'h00, a); check("R3 sub ack", a, 1'b1);
    tx_byte(8'h35, a); check("R4 data ack", a, 1'b1);
    bus_stop();
    check("R4 reg0 written", regs, 16'h0035);
    check("R8 sda released after stop", sda_oe, 1'b0);
  endtask

  task automatic t_burst_wrap();
    logic a;
    bus_start();
    tx_byte(AW, a); tx_byte(8'h01, a);
    tx_byte(8'hA1, a); check("R4 byte1 ack", a, 1'b1);
    tx_byte(8'h5C, a); check("R4 wrap ack", a, 1'b1);
    bus_stop();
    check("R4 wrap regs", regs, 16'hA15C);
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    bus_start();
    tx_byte(AR, a); check("R1 read addr ack", a, 1'b1);
    rx_byte(1'b1, d); check("R5 current read", d, 8'hA1);
    rx_byte(1'b0, d); check("R6 read wraps", d, 8'h5C);
    bus_stop();
  endtask

  task automatic t_random_read();
    logic a; logic [7:0] d;
    bus_start();
    tx_byte(AW, a); tx_byte(8'hFE, a); check("R3 upper bits ignored ack", a, 1'b1);
    bus_start();
    tx_byte(AR, a); check("R6 restart addr ack", a, 1'b1);
    rx_byte(1'b1, d); check("R6 random first", d, 8'h5C);
    rx_byte(1'b0, d); check("R6 random second", d, 8'hA1);
    bus_stop();
  endtask

  task automatic t_nack_hold();
    logic a; logic [7:0] d;
    bus_start(); tx_byte(AR, a); rx_byte(1'b0, d); bus_stop();
    check("R7 first after wrap", d, 8'h5C);
    check("R7 sda released", sda_oe, 1'b0);
    bus_start(); tx_byte(AR, a); rx_byte(1'b0, d); bus_stop();
    check("R7 next current read", d, 8'hA1);
  endtask

  task automatic t_foreign();
    logic a; logic [7:0] d;
    bus_start();
    tx_byte(FW, a); check("R2 no addr ack", a, 1'b0);
    tx_byte(8'h00, a); check("R2 no sub ack", a, 1'b0);
    tx_byte(8'hFF, a); check("R2 no data ack", a, 1'b0);
    bus_stop();
    check("R2 regs untouched", regs, 16'hA15C);
    bus_start();
    tx_byte(FR, a); check("R2 no read ack", a, 1'b0);
    rx_byte(1'b0, d); check("R2 bus idle high", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_restart_abort();
    logic a; logic [7:0] d;
    bus_start();
    tx_byte(AW, a); tx_byte(8'h00, a);
    for (int i = 0; i < 4; i++) tx_bit(1'b1);
    bus_start();
    tx_byte(AR, a); check("R8 rearmed addr ack", a, 1'b1);
    rx_byte(1'b0, d); check("R8 partial byte dropped", d, 8'h5C);
    bus_stop();
    check("R8 regs unchanged", regs, 16'hA15C);
  endtask

  task automatic t_power_down();
    logic a; logic [7:0] d;
    @(negedge clk); rst_n = 1'b0; wq(); rst_n = 1'b1; wq();
    check("R9 regs cleared", regs, 16'h0000);
    bus_start(); tx_byte(AW, a); tx_byte(8'h01, a); tx_byte(8'h77, a); bus_stop();
    check("R9 write after reset", regs, 16'h7700);
    @(negedge clk); rst_n = 1'b0; wq(); rst_n = 1'b1; wq();
    bus_start(); tx_byte(AR, a); rx_byte(1'b0, d); bus_stop();
    check("R9 index back to 00", d, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();
    t_reset();
    t_single_write();
    t_burst_wrap();
    t_current_read();
    t_random_read();
    t_nack_hold();
    t_foreign();
    t_restart_abort();
    t_power_down();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule